// File: doc/BRIEF.md
# Reservation Station Bank with Tag Wakeup

This block is the waiting room of an out-of-order scheduler that renames by copying values. It holds a small, fixed set of slots, each tied to one kind of execution unit: one integer slot, one load slot, one store slot and two floating-point slots. A dispatched instruction takes the lowest-numbered free slot of its kind. For each source it gets either a value read from the register file, or the tag of the slot that will produce that value. The slot's own tag is its slot number plus one. Tag zero means no producer is pending.

Slots watch a single result bus that carries a tag and a value. When a pending source tag matches the bus tag, the slot copies the value and the tag becomes zero. A slot requests issue once both source tags are clear. An external selector grants one slot at a time. The granted slot's opcode, destination, stored values and tag appear on the issue outputs in that same cycle.

Each slot is a three-state machine:
- IDLE: the slot is free. The allocate transition moves it to WAIT.
- WAIT: the slot is occupied and may request issue. The grant transition moves it to SENT.
- SENT: the slot is occupied but no longer requests. The writeback transition returns it to IDLE. The writeback-and-allocate transition, taken when both happen in one cycle, moves it straight back to WAIT with the new instruction.

Top module: `rs_array`

## Requirements
- R1: A synchronous reset empties every slot. After reset `ready_vec` is zero, and a dispatch of any kind does not stall.
- R2: The `disp_kind` code selects the slots:
  - 0 (integer) takes tag 1.
  - 1 (load) takes tag 2.
  - 2 (store) takes tag 3.
  - 3 (floating-point) takes tag 4, or tag 5 when tag 4 is occupied.
  - `disp_tag` reports the tag taken in that cycle.
- R3: When no slot of the requested kind is free, `disp_stall` is 1 and `disp_tag` is 0. Nothing is written into any slot.
- R4: A source with tag 0 at dispatch captures the value given on its value input. A slot whose two sources are both tag 0 raises its `ready_vec` bit in the next cycle.
- R5: A source with a nonzero tag at dispatch keeps the slot's `ready_vec` bit low until that tag is broadcast.
- R6: When `cdb_valid` is high and `cdb_tag` equals a waiting source tag, the slot copies `cdb_value`, and that source counts as clear from then on.
- R7: A slot whose last pending tag is being broadcast raises its `ready_vec` bit in that same cycle. If it is granted in that cycle, the broadcast value appears on the issue output.
- R8: A dispatched source whose tag equals the tag broadcast in the same cycle captures the broadcast value directly, so the wakeup is not lost.
- R9: A granted slot drops its `ready_vec` bit from the next cycle on. It stays occupied, so a further dispatch of its kind stalls, until its writeback.
- R10: `wb_valid` with `wb_tag` frees that slot. A dispatch of the same kind in the same cycle takes that slot without stalling.
- R11: A broadcast whose tag matches no pending source changes no slot.
- R12: While `issue_grant` has exactly one bit set on a ready slot, the issue outputs carry that slot's opcode, destination, two source values and tag. With no grant they are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| disp_valid | input | 1 | An instruction is offered for dispatch |
| disp_kind | input | 2 | Unit kind: 0 integer, 1 load, 2 store, 3 floating-point |
| disp_op | input | 4 | Opcode |
| disp_dest | input | 5 | Destination register name |
| disp_src1_tag | input | 3 | Producer tag of source 1, 0 if the value is available |
| disp_src1_val | input | 32 | Register-file value of source 1 |
| disp_src2_tag | input | 3 | Producer tag of source 2, 0 if the value is available |
| disp_src2_val | input | 32 | Register-file value of source 2 |
| disp_stall | output | 1 | No free slot of the offered kind |
| disp_tag | output | 3 | Tag of the slot taken this cycle, 0 if none |
| cdb_valid | input | 1 | Result broadcast is valid |
| cdb_tag | input | 3 | Tag of the broadcast result |
| cdb_value | input | 32 | Broadcast result value |
| wb_valid | input | 1 | A slot finishes writeback this cycle |
| wb_tag | input | 3 | Tag of the slot finishing writeback |
| ready_vec | output | 5 | Per-slot issue request, bit i is tag i+1 |
| issue_grant | input | 5 | One-hot grant from the external selector |
| issue_op | output | 4 | Opcode of the granted slot |
| issue_dest | output | 5 | Destination of the granted slot |
| issue_src1 | output | 32 | Source 1 value of the granted slot |
| issue_src2 | output | 32 | Source 2 value of the granted slot |
| issue_tag | output | 3 | Tag of the granted slot |

## Verification
Two pairs of events are driven into the same cycle on purpose.

The first pair is a result broadcast together with an issue grant. A floating-point slot waits on the load tag. In the cycle the load tag is broadcast, the bench grants that slot, and it expects both the `ready_vec` bit and the broadcast value on `issue_src2` in that very cycle.

The second pair is a writeback together with a dispatch. The integer slot is freed while a new integer instruction is offered. The bench expects no stall and tag 1. A separate broadcast-during-dispatch case is then checked through the values the new slot later issues.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        KIND_INT   = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_STORE = 2'd2,
        KIND_FP    = 2'd3
    } unit_kind_e;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_SENT = 2'd2
    } slot_state_e;

    // Slot layout: integer slots first, then load, store, floating-point.
    function automatic unit_kind_e kind_of(input int idx, input int n_int,
                                           input int n_load, input int n_store);
        if (idx < n_int)                         return KIND_INT;
        else if (idx < n_int + n_load)           return KIND_LOAD;
        else if (idx < n_int + n_load + n_store) return KIND_STORE;
        else                                     return KIND_FP;
    endfunction

endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] eligible_i,
    output logic [N-1:0] pick_o
);
    logic taken;

    // Lowest index wins.
    always_comb begin
        taken  = 1'b0;
        pick_o = '0;
        for (int i = 0; i < N; i++) begin
            pick_o[i] = eligible_i[i] && !taken;
            taken     = taken || eligible_i[i];
        end
    end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OP_W   = 4,
    parameter int DEST_W = 5,
    parameter int TAG_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       alloc_i,
    input  logic                       grant_i,
    input  logic                       free_i,
    input  logic [OP_W-1:0]            op_i,
    input  logic [DEST_W-1:0]          dest_i,
    input  logic [1:0][TAG_W-1:0]      src_tag_i,
    input  logic [1:0][DATA_W-1:0]     src_val_i,
    input  logic                       cdb_valid_i,
    input  logic [TAG_W-1:0]           cdb_tag_i,
    input  logic [DATA_W-1:0]          cdb_val_i,
    output logic                       avail_o,
    output logic                       ready_o,
    output logic [OP_W-1:0]            op_o,
    output logic [DEST_W-1:0]          dest_o,
    output logic [1:0][DATA_W-1:0]     src_val_o
);
    localparam int NSRC = 2;

    slot_state_e state_q, state_d;
    logic [NSRC-1:0][TAG_W-1:0]  tag_q;
    logic [NSRC-1:0][DATA_W-1:0] val_q;
    logic [OP_W-1:0]             op_q;
    logic [DEST_W-1:0]           dest_q;
    logic [NSRC-1:0]             hit;
    logic [NSRC-1:0]             clear;

    // Snoop of the result bus for each waiting source.
    always_comb begin
        for (int k = 0; k < NSRC; k++) begin
            hit[k]   = (state_q == SLOT_WAIT) && cdb_valid_i &&
                       (tag_q[k] != '0) && (cdb_tag_i == tag_q[k]);
            clear[k] = (tag_q[k] == '0) || hit[k];
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: if (alloc_i) state_d = SLOT_WAIT;
            SLOT_WAIT: if (grant_i) state_d = SLOT_SENT;
            SLOT_SENT: begin
                if (alloc_i)     state_d = SLOT_WAIT;
                else if (free_i) state_d = SLOT_IDLE;
            end
            default:             state_d = SLOT_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= SLOT_IDLE;
        else     state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        avail_o = (state_q == SLOT_IDLE) || ((state_q == SLOT_SENT) && free_i);
        ready_o = (state_q == SLOT_WAIT) && (&clear);
        op_o    = op_q;
        dest_o  = dest_q;
        for (int k = 0; k < NSRC; k++)
            src_val_o[k] = hit[k] ? cdb_val_i : val_q[k];
    end

    // Operand storage: fill at dispatch, capture on broadcast.
    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '0;
            val_q  <= '0;
            op_q   <= '0;
            dest_q <= '0;
        end else if (alloc_i) begin
            op_q   <= op_i;
            dest_q <= dest_i;
            for (int k = 0; k < NSRC; k++) begin
                if (src_tag_i[k] == '0) begin
                    tag_q[k] <= '0;
                    val_q[k] <= src_val_i[k];
                end else if (cdb_valid_i && (cdb_tag_i == src_tag_i[k])) begin
                    tag_q[k] <= '0;
                    val_q[k] <= cdb_val_i;
                end else begin
                    tag_q[k] <= src_tag_i[k];
                    val_q[k] <= '0;
                end
            end
        end else begin
            for (int k = 0; k < NSRC; k++) begin
                if (hit[k]) begin
                    tag_q[k] <= '0;
                    val_q[k] <= cdb_val_i;
                end
            end
        end
    end

    // R12
    grant_on_ready_chk: assert property (@(posedge clk) disable iff (rst)
        grant_i |-> ready_o);

    // R9
    grant_drops_request_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_i && !alloc_i) |=> !ready_o);

    // R10
    alloc_into_free_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_i |-> avail_o);

    // R6
    capture_src0_chk: assert property (@(posedge clk) disable iff (rst)
        hit[0] |=> (tag_q[0] == '0) && (val_q[0] == $past(cdb_val_i)));

    // R6
    capture_src1_chk: assert property (@(posedge clk) disable iff (rst)
        hit[1] |=> (tag_q[1] == '0) && (val_q[1] == $past(cdb_val_i)));

endmodule

// File: rtl/rs_issue_mux.sv
module rs_issue_mux #(
    parameter int N      = 5,
    parameter int DATA_W = 32,
    parameter int OP_W   = 4,
    parameter int DEST_W = 5,
    parameter int TAG_W  = 3
) (
    input  logic [N-1:0]                grant_i,
    input  logic [N-1:0][OP_W-1:0]      op_i,
    input  logic [N-1:0][DEST_W-1:0]    dest_i,
    input  logic [N-1:0][DATA_W-1:0]    src1_i,
    input  logic [N-1:0][DATA_W-1:0]    src2_i,
    output logic [OP_W-1:0]             op_o,
    output logic [DEST_W-1:0]           dest_o,
    output logic [DATA_W-1:0]           src1_o,
    output logic [DATA_W-1:0]           src2_o,
    output logic [TAG_W-1:0]            tag_o
);
    // AND-OR select; all zero when no grant.
    always_comb begin
        op_o   = '0;
        dest_o = '0;
        src1_o = '0;
        src2_o = '0;
        tag_o  = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_i[i]) begin
                op_o   = op_o   | op_i[i];
                dest_o = dest_o | dest_i[i];
                src1_o = src1_o | src1_i[i];
                src2_o = src2_o | src2_i[i];
                tag_o  = tag_o  | TAG_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/rs_array.sv
module rs_array
    import rs_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int OP_W    = 4,
    parameter int DEST_W  = 5,
    parameter int N_INT   = 1,
    parameter int N_LOAD  = 1,
    parameter int N_STORE = 1,
    parameter int N_FP    = 2,
    localparam int NUM_RS = N_INT + N_LOAD + N_STORE + N_FP,
    localparam int TAG_W  = $clog2(NUM_RS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_valid,
    input  logic [1:0]        disp_kind,
    input  logic [OP_W-1:0]   disp_op,
    input  logic [DEST_W-1:0] disp_dest,
    input  logic [TAG_W-1:0]  disp_src1_tag,
    input  logic [DATA_W-1:0] disp_src1_val,
    input  logic [TAG_W-1:0]  disp_src2_tag,
    input  logic [DATA_W-1:0] disp_src2_val,
    output logic              disp_stall,
    output logic [TAG_W-1:0]  disp_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    output logic [NUM_RS-1:0] ready_vec,
    input  logic [NUM_RS-1:0] issue_grant,
    output logic [OP_W-1:0]   issue_op,
    output logic [DEST_W-1:0] issue_dest,
    output logic [DATA_W-1:0] issue_src1,
    output logic [DATA_W-1:0] issue_src2,
    output logic [TAG_W-1:0]  issue_tag
);
    logic [NUM_RS-1:0]              avail;
    logic [NUM_RS-1:0]              eligible;
    logic [NUM_RS-1:0]              alloc_vec;
    logic [NUM_RS-1:0]              free_vec;
    logic [NUM_RS-1:0][OP_W-1:0]    slot_op;
    logic [NUM_RS-1:0][DEST_W-1:0]  slot_dest;
    logic [NUM_RS-1:0][DATA_W-1:0]  slot_src1;
    logic [NUM_RS-1:0][DATA_W-1:0]  slot_src2;
    logic [1:0][TAG_W-1:0]          src_tags;
    logic [1:0][DATA_W-1:0]         src_vals;

    assign src_tags = {disp_src2_tag, disp_src1_tag};
    assign src_vals = {disp_src2_val, disp_src1_val};

    for (genvar i = 0; i < NUM_RS; i++) begin : g_slot
        localparam unit_kind_e KIND = kind_of(i, N_INT, N_LOAD, N_STORE);
        logic [1:0][DATA_W-1:0] fwd;

        assign free_vec[i] = wb_valid && (wb_tag == TAG_W'(i + 1));
        assign eligible[i] = disp_valid && avail[i] && (disp_kind == KIND);

        rs_slot #(
            .DATA_W(DATA_W), .OP_W(OP_W), .DEST_W(DEST_W), .TAG_W(TAG_W)
        ) u_slot (
            .clk        (clk),
            .rst        (rst),
            .alloc_i    (alloc_vec[i]),
            .grant_i    (issue_grant[i]),
            .free_i     (free_vec[i]),
            .op_i       (disp_op),
            .dest_i     (disp_dest),
            .src_tag_i  (src_tags),
            .src_val_i  (src_vals),
            .cdb_valid_i(cdb_valid),
            .cdb_tag_i  (cdb_tag),
            .cdb_val_i  (cdb_value),
            .avail_o    (avail[i]),
            .ready_o    (ready_vec[i]),
            .op_o       (slot_op[i]),
            .dest_o     (slot_dest[i]),
            .src_val_o  (fwd)
        );

        assign slot_src1[i] = fwd[0];
        assign slot_src2[i] = fwd[1];
    end

    rs_pick #(.N(NUM_RS)) u_pick (
        .eligible_i(eligible),
        .pick_o    (alloc_vec)
    );

    assign disp_stall = disp_valid && (eligible == '0);

    always_comb begin
        disp_tag = '0;
        for (int i = 0; i < NUM_RS; i++)
            if (alloc_vec[i]) disp_tag = disp_tag | TAG_W'(i + 1);
    end

    rs_issue_mux #(
        .N(NUM_RS), .DATA_W(DATA_W), .OP_W(OP_W), .DEST_W(DEST_W), .TAG_W(TAG_W)
    ) u_issue (
        .grant_i(issue_grant),
        .op_i   (slot_op),
        .dest_i (slot_dest),
        .src1_i (slot_src1),
        .src2_i (slot_src2),
        .op_o   (issue_op),
        .dest_o (issue_dest),
        .src1_o (issue_src1),
        .src2_o (issue_src2),
        .tag_o  (issue_tag)
    );

    // R2
    single_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(alloc_vec));

    // R3
    stall_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        disp_stall |-> (alloc_vec == '0) && (disp_tag == '0));

    // R12
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(issue_grant));

endmodule

// File: tb/rs_array_bench.sv
module rs_array_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int OW = 4;
    localparam int RW = 5;
    localparam int TW = 3;
    localparam int N  = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic          disp_valid;
    logic [1:0]    disp_kind;
    logic [OW-1:0] disp_op;
    logic [RW-1:0] disp_dest;
    logic [TW-1:0] disp_src1_tag, disp_src2_tag;
    logic [DW-1:0] disp_src1_val, disp_src2_val;
    logic          disp_stall;
    logic [TW-1:0] disp_tag;
    logic          cdb_valid;
    logic [TW-1:0] cdb_tag;
    logic [DW-1:0] cdb_value;
    logic          wb_valid;
    logic [TW-1:0] wb_tag;
    logic [N-1:0]  ready_vec;
    logic [N-1:0]  issue_grant;
    logic [OW-1:0] issue_op;
    logic [RW-1:0] issue_dest;
    logic [DW-1:0] issue_src1, issue_src2;
    logic [TW-1:0] issue_tag;

    rs_array u_rs_array (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_kind(disp_kind), .disp_op(disp_op),
        .disp_dest(disp_dest), .disp_src1_tag(disp_src1_tag),
        .disp_src1_val(disp_src1_val), .disp_src2_tag(disp_src2_tag),
        .disp_src2_val(disp_src2_val), .disp_stall(disp_stall), .disp_tag(disp_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .ready_vec(ready_vec),
        .issue_grant(issue_grant), .issue_op(issue_op), .issue_dest(issue_dest),
        .issue_src1(issue_src1), .issue_src2(issue_src2), .issue_tag(issue_tag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [OW-1:0] op;
        logic [RW-1:0] dest;
        logic [DW-1:0] v1;
        logic [DW-1:0] v2;
        logic [TW-1:0] tag;
        string         req;
    } issue_exp_t;

    issue_exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare every granted issue against the scoreboard.
    issue_exp_t mon_e;
    always @(negedge clk) begin
        if (!rst && issue_grant != '0) begin
            if (exp_q.size() == 0) begin
                check("R12", "unexpected issue", 64'(issue_grant), 64'd0);
            end else begin
                mon_e = exp_q.pop_front();
                check(mon_e.req, "issue_op",   64'(issue_op),   64'(mon_e.op));
                check(mon_e.req, "issue_dest", 64'(issue_dest), 64'(mon_e.dest));
                check(mon_e.req, "issue_src1", 64'(issue_src1), 64'(mon_e.v1));
                check(mon_e.req, "issue_src2", 64'(issue_src2), 64'(mon_e.v2));
                check(mon_e.req, "issue_tag",  64'(issue_tag),  64'(mon_e.tag));
            end
        end
    end

    task automatic idle_inputs();
        disp_valid = 0; disp_kind = 0; disp_op = 0; disp_dest = 0;
        disp_src1_tag = 0; disp_src1_val = 0; disp_src2_tag = 0; disp_src2_val = 0;
        cdb_valid = 0; cdb_tag = 0; cdb_value = 0;
        wb_valid = 0; wb_tag = 0; issue_grant = 0;
    endtask

    task automatic next_cycle();
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic dispatch(input logic [1:0] k, input logic [OW-1:0] op,
                            input logic [RW-1:0] d,
                            input logic [TW-1:0] t1, input logic [DW-1:0] v1,
                            input logic [TW-1:0] t2, input logic [DW-1:0] v2);
        disp_valid = 1; disp_kind = k; disp_op = op; disp_dest = d;
        disp_src1_tag = t1; disp_src1_val = v1; disp_src2_tag = t2; disp_src2_val = v2;
    endtask

    task automatic grant(input int idx, input logic [OW-1:0] op, input logic [RW-1:0] d,
                         input logic [DW-1:0] v1, input logic [DW-1:0] v2,
                         input string req);
        issue_exp_t e;
        issue_grant = N'(1) << idx;
        e.op = op; e.dest = d; e.v1 = v1; e.v2 = v2; e.tag = TW'(idx + 1); e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic broadcast(input logic [TW-1:0] t, input logic [DW-1:0] v);
        cdb_valid = 1; cdb_tag = t; cdb_value = v;
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R1", "ready_vec after reset", 64'(ready_vec), 64'd0);
        check("R12", "issue_tag with no grant", 64'(issue_tag), 64'd0);

        // a: integer op, both sources from the register file
        next_cycle();
        dispatch(2'd0, 4'd1, 5'd3, 0, 32'd10, 0, 32'd20);
        @(negedge clk);
        check("R1", "no stall on first dispatch", 64'(disp_stall), 64'd0);
        check("R2", "integer slot tag", 64'(disp_tag), 64'd1);

        // b: issue it; dispatch FP waiting on load tag 2
        next_cycle();
        grant(0, 4'd1, 5'd3, 32'd10, 32'd20, "R4");
        dispatch(2'd3, 4'd2, 5'd4, 0, 32'd7, 3'd2, 32'd0);
        @(negedge clk);
        check("R4", "ready after register-file fill", 64'(ready_vec), 64'b00001);
        check("R2", "first FP slot tag", 64'(disp_tag), 64'd4);

        // c: integer slot issued but busy; unrelated broadcast
        next_cycle();
        dispatch(2'd0, 4'd5, 5'd6, 0, 32'd1, 0, 32'd1);
        broadcast(3'd5, 32'd99);
        @(negedge clk);
        check("R9", "stall while issued slot not written back", 64'(disp_stall), 64'd1);
        check("R9", "granted slot stops requesting, R5 FP waits", 64'(ready_vec), 64'd0);

        // d: load
        next_cycle();
        dispatch(2'd1, 4'd3, 5'd1, 0, 32'd100, 0, 32'd0);
        @(negedge clk);
        check("R2", "load slot tag", 64'(disp_tag), 64'd2);
        check("R11", "non-matching broadcast left FP waiting", 64'(ready_vec), 64'd0);

        // e: broadcast tag 2 wakes FP and grants it same cycle; writeback + dispatch
        next_cycle();
        broadcast(3'd2, 32'd55);
        grant(3, 4'd2, 5'd4, 32'd7, 32'd55, "R7");
        wb_valid = 1; wb_tag = 3'd1;
        dispatch(2'd0, 4'd5, 5'd6, 3'd4, 32'd0, 0, 32'd5);
        @(negedge clk);
        check("R7", "same-cycle wakeup", 64'(ready_vec), 64'b01010);
        check("R10", "no stall on writeback+dispatch", 64'(disp_stall), 64'd0);
        check("R10", "freed slot reused", 64'(disp_tag), 64'd1);

        // f: FP dispatch with source tag 4 while tag 4 is broadcast
        next_cycle();
        dispatch(2'd3, 4'd7, 5'd8, 0, 32'd3, 3'd4, 32'd0);
        broadcast(3'd4, 32'd77);
        @(negedge clk);
        check("R2", "second FP slot tag", 64'(disp_tag), 64'd5);
        check("R6", "integer slot wakes on tag 4", 64'(ready_vec), 64'b00011);

        // g: R8 slot ready; issue integer slot with captured value
        next_cycle();
        grant(0, 4'd5, 5'd6, 32'd77, 32'd5, "R6");
        @(negedge clk);
        check("R8", "dispatch-time capture makes slot ready", 64'(ready_vec), 64'b10011);

        // h: issue second FP slot
        next_cycle();
        grant(4, 4'd7, 5'd8, 32'd3, 32'd77, "R8");
        @(negedge clk);
        check("R9", "ready after two grants", 64'(ready_vec), 64'b10010);

        // i: both FP slots occupied
        next_cycle();
        dispatch(2'd3, 4'd9, 5'd9, 0, 32'd9, 0, 32'd9);
        @(negedge clk);
        check("R3", "FP stall", 64'(disp_stall), 64'd1);
        check("R3", "no tag on stall", 64'(disp_tag), 64'd0);

        // j: store
        next_cycle();
        dispatch(2'd2, 4'd9, 5'd0, 0, 32'd1, 0, 32'd2);
        @(negedge clk);
        check("R2", "store slot tag", 64'(disp_tag), 64'd3);
        check("R3", "stalled dispatch wrote nothing", 64'(ready_vec), 64'b00010);

        // k: store becomes ready
        next_cycle();
        @(negedge clk);
        check("R4", "store ready", 64'(ready_vec), 64'b00110);
        check("R12", "issue outputs zero without grant", 64'(issue_src1), 64'd0);

        // l: issue store
        next_cycle();
        grant(2, 4'd9, 5'd0, 32'd1, 32'd2, "R12");
        next_cycle();
        @(negedge clk);
        check("R12", "scoreboard drained", 64'(exp_q.size()), 64'd0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule